// File: doc/BRIEF.md
# Multi-Packet Vector Framing Aligner

This block sits between a packetized sample stream and a vector-processing core such as a transform engine. Each vector is longer than one packet, so it travels as a fixed group of consecutive packets. The block collects one full vector into a local buffer and tracks where each packet belongs in its group. It releases the vector only once every packet of the group has arrived intact and in order. A packet's place in the group comes from the low bits of its 12-bit sequence number, counted from a phase that is latched at the start of each burst. A lost packet, an overflow marker or a malformed packet therefore costs exactly one vector. Later vectors keep their boundaries.

A released vector passes through a fixed-latency stage that stands in for the processing core. It then leaves the block cut into packets of the input packet length, with a separate flag on the final sample of each vector. The vector length, the packet length and the group size are all configured as base-2 logarithms. Two saturating 16-bit status counters report discarded vectors and realignment events. A sticky flag reports an inconsistent configuration.

Top module: `vec_frame_aligner`

## Requirements
- R1: After reset, m_valid is 0, s_ready is 1, cfg_err is 0, and both status counters read 0.
- R2: A packet's group position is (s_seq − phase) mod 2^cfg_grp_log2. Phase is s_seq of the first packet after reset or after an end-of-burst. A run of 2^cfg_grp_log2 packets with consecutive sequence numbers and positions 0,1,… is released as one vector, in arrival order, with m_vlast set on its last sample only.
- R3: Output samples carry m_last on every 2^cfg_pkt_log2-th sample of a vector, whatever the group size. m_vlast is only ever set together with m_last.
- R4: At a packet start, a sequence gap (s_seq ≠ previous s_seq + 1 mod 4096) or a wrong position increments realign_cnt. If a partial vector is held, it is discarded and drop_cnt is incremented. A packet at position 0 then starts a new vector at once.
- R5: After a misalignment, whole packets are ignored until a packet at position 0 arrives.
- R6: s_ovf set on any accepted beat of a vector being gathered discards that vector, increments drop_cnt and leaves realign_cnt unchanged.
- R7: s_eob on the last beat of a packet ends assembly. A partial vector is discarded and counted in drop_cnt. The next packet begins a new vector at position 0 with no gap check.
- R8: A packet whose s_last does not fall on beat 2^cfg_pkt_log2 − 1 discards its vector and increments both drop_cnt and realign_cnt.
- R9: If cfg_vec_log2 ≠ cfg_pkt_log2 + cfg_grp_log2, or cfg_vec_log2 exceeds MAX_VEC_LOG2, cfg_err sets and stays set until reset. While it is set, input is accepted and thrown away, and nothing is produced.
- R10: Each status counter rises by at most one per cycle and holds at 0xFFFF.
- R11: No sample is lost or reordered under output backpressure. m_data and its flags hold while m_valid is high and m_ready is low. s_ready is low while a released vector is draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_vec_log2 | input | 4 | log2 of vector length |
| cfg_pkt_log2 | input | 4 | log2 of packet length |
| cfg_grp_log2 | input | 4 | log2 of packets per vector |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample accepted |
| s_data | input | DATA_W | Input sample |
| s_last | input | 1 | Last beat of input packet |
| s_seq | input | 12 | Packet sequence number, read on the first beat |
| s_eob | input | 1 | End of burst, read with s_last |
| s_ovf | input | 1 | Overflow marker on this beat |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | DATA_W | Output sample |
| m_last | output | 1 | Last sample of output packet |
| m_vlast | output | 1 | Last sample of vector |
| cfg_err | output | 1 | Sticky configuration error |
| drop_cnt | output | 16 | Discarded vectors, saturating |
| realign_cnt | output | 16 | Realignment events, saturating |

## Verification
The bench sends a gap that falls in the middle of a vector. A design that keeps the partial vector would stitch packets from two groups together. The bench also sends a gap that lands on an odd position, where a design without hunting would start a vector at the wrong phase and shift every later frame. Overflow and short packets are placed mid-vector, so a design that releases or miscounts would show extra samples or wrong counter values. An end-of-burst mid-vector, followed by a packet with odd phase, shows whether the phase is latched afresh. Throttled output readiness reveals lost or duplicated samples and an input that is not stalled during draining.

// File: rtl/vfa_pkg.sv
`timescale 1ns/1ps
package vfa_pkg;
    localparam int SEQ_W = 12;
    localparam int CNT_W = 16;
    localparam int LOG_W = 4;

    typedef enum logic [1:0] {
        TRK_FRESH   = 2'd0,
        TRK_COLLECT = 2'd1,
        TRK_HUNT    = 2'd2
    } trk_state_e;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v, input logic en);
        return (en && (v != '1)) ? v + 1'b1 : v;
    endfunction

    function automatic logic cfg_invalid(input logic [LOG_W-1:0] vl,
                                         input logic [LOG_W-1:0] pl,
                                         input logic [LOG_W-1:0] gl,
                                         input int max_log2);
        logic [LOG_W:0] sum;
        sum = {1'b0, pl} + {1'b0, gl};
        return ({1'b0, vl} != sum) || (int'(vl) > max_log2);
    endfunction
endpackage

// File: rtl/vfa_store.sv
`timescale 1ns/1ps
module vfa_store #(
    parameter int DATA_W = 32,
    parameter int VEC_AW = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [VEC_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [VEC_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << VEC_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/vfa_tracker.sv
`timescale 1ns/1ps
module vfa_tracker
    import vfa_pkg::*;
#(
    parameter int VEC_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LOG_W-1:0]  cfg_vec_log2,
    input  logic [LOG_W-1:0]  cfg_pkt_log2,
    input  logic [LOG_W-1:0]  cfg_grp_log2,
    input  logic              s_valid,
    input  logic              s_last,
    input  logic [SEQ_W-1:0]  s_seq,
    input  logic              s_eob,
    input  logic              s_ovf,
    input  logic              drain_busy,
    output logic              s_ready,
    output logic              wr_en,
    output logic [VEC_AW-1:0] wr_addr,
    output logic              vec_done,
    output logic              cfg_err,
    output logic [CNT_W-1:0]  drop_cnt,
    output logic [CNT_W-1:0]  realign_cnt
);
    trk_state_e        state, nstate;
    logic [VEC_AW-1:0] wr, nwr, wr_eff;
    logic [SEQ_W-1:0]  phase, nphase, phase_eff, prev_seq, pos;
    logic              have_prev, in_pkt;
    logic              cfg_bad, cfg_block, acc, first, seq_gap;
    logic              take, bad_pkt, drop_inc, realign_inc;
    logic [VEC_AW-1:0] pmask;
    logic [SEQ_W-1:0]  gmask;

    assign cfg_bad   = cfg_invalid(cfg_vec_log2, cfg_pkt_log2, cfg_grp_log2, VEC_AW);
    assign cfg_block = cfg_err | cfg_bad;
    assign s_ready   = cfg_block | ~drain_busy;
    assign acc       = s_valid & ~drain_busy & ~cfg_block;
    assign pmask     = (VEC_AW'(1) << cfg_pkt_log2) - 1'b1;
    assign gmask     = (SEQ_W'(1) << cfg_grp_log2) - 1'b1;
    assign first     = ~in_pkt;
    assign seq_gap   = have_prev && (s_seq != prev_seq + 1'b1);
    assign phase_eff = (state == TRK_FRESH) ? s_seq : phase;
    assign pos       = (s_seq - phase_eff) & gmask;

    always_comb begin
        nstate      = state;
        nwr         = wr;
        nphase      = phase;
        wr_eff      = wr;
        take        = 1'b0;
        bad_pkt     = 1'b0;
        drop_inc    = 1'b0;
        realign_inc = 1'b0;
        vec_done    = 1'b0;
        if (acc) begin
            unique case (state)
                TRK_FRESH: begin
                    if (first) begin
                        take   = 1'b1;
                        wr_eff = '0;
                        nphase = s_seq;
                    end
                end
                TRK_COLLECT: begin
                    if (first && (seq_gap || pos != SEQ_W'(wr >> cfg_pkt_log2))) begin
                        realign_inc = 1'b1;
                        if (wr != '0) drop_inc = 1'b1;
                        if (pos == '0) begin
                            take   = 1'b1;
                            wr_eff = '0;
                        end else begin
                            nstate = TRK_HUNT;
                            nwr    = '0;
                        end
                    end else begin
                        take = 1'b1;
                    end
                end
                TRK_HUNT: begin
                    if (first && pos == '0) begin
                        take   = 1'b1;
                        wr_eff = '0;
                    end
                end
                default: nstate = TRK_FRESH;
            endcase

            if (take) begin
                bad_pkt = s_ovf || (s_last != ((wr_eff & pmask) == pmask));
                if (bad_pkt) begin
                    drop_inc = 1'b1;
                    if (s_last != ((wr_eff & pmask) == pmask)) realign_inc = 1'b1;
                    nstate = TRK_HUNT;
                    nwr    = '0;
                end else if (s_last && SEQ_W'(wr_eff >> cfg_pkt_log2) == gmask) begin
                    vec_done = 1'b1;
                    nstate   = TRK_COLLECT;
                    nwr      = '0;
                end else begin
                    nstate = TRK_COLLECT;
                    nwr    = wr_eff + 1'b1;
                end
            end

            if (s_last && s_eob) begin
                if (take && !vec_done && !bad_pkt) drop_inc = 1'b1;
                nstate = TRK_FRESH;
                nwr    = '0;
            end
        end
    end

    assign wr_en   = acc & take;
    assign wr_addr = wr_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= TRK_FRESH;
            wr          <= '0;
            phase       <= '0;
            prev_seq    <= '0;
            have_prev   <= 1'b0;
            in_pkt      <= 1'b0;
            cfg_err     <= 1'b0;
            drop_cnt    <= '0;
            realign_cnt <= '0;
        end else begin
            cfg_err     <= cfg_err | cfg_bad;
            drop_cnt    <= sat_inc(drop_cnt, drop_inc);
            realign_cnt <= sat_inc(realign_cnt, realign_inc);
            state       <= nstate;
            wr          <= nwr;
            phase       <= nphase;
            if (acc) begin
                in_pkt <= ~s_last;
                if (first) begin
                    prev_seq  <= s_seq;
                    have_prev <= 1'b1;
                end
                if (s_last && s_eob) have_prev <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vfa_drain.sv
`timescale 1ns/1ps
module vfa_drain
    import vfa_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int VEC_AW = 10,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LOG_W-1:0]  cfg_vec_log2,
    input  logic [LOG_W-1:0]  cfg_pkt_log2,
    input  logic              vec_done,
    output logic [VEC_AW-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              m_ready,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_data,
    output logic              m_last,
    output logic              m_vlast,
    output logic              busy
);
    typedef struct packed {
        logic              vld;
        logic              plast;
        logic              vlast;
        logic [DATA_W-1:0] data;
    } stage_t;

    stage_t            pipe [LAT];
    stage_t            head;
    logic [VEC_AW-1:0] rd, vmask, pmask;
    logic              adv;

    assign vmask = (VEC_AW'(1) << cfg_vec_log2) - 1'b1;
    assign pmask = (VEC_AW'(1) << cfg_pkt_log2) - 1'b1;
    assign adv   = ~pipe[LAT-1].vld | m_ready;

    assign rd_addr    = rd;
    assign head.vld   = busy;
    assign head.plast = (rd & pmask) == pmask;
    assign head.vlast = rd == vmask;
    assign head.data  = rd_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            rd   <= '0;
        end else if (vec_done) begin
            busy <= 1'b1;
            rd   <= '0;
        end else if (busy && adv) begin
            rd <= rd + 1'b1;
            if (rd == vmask) busy <= 1'b0;
        end
    end

    generate
        for (genvar i = 0; i < LAT; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    pipe[i] <= '0;
                end else if (adv) begin
                    if (i == 0) pipe[i] <= head;
                    else        pipe[i] <= pipe[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign m_valid = pipe[LAT-1].vld;
    assign m_data  = pipe[LAT-1].data;
    assign m_last  = pipe[LAT-1].vld & pipe[LAT-1].plast;
    assign m_vlast = pipe[LAT-1].vld & pipe[LAT-1].vlast;
endmodule

// File: rtl/vec_frame_aligner.sv
`timescale 1ns/1ps
module vec_frame_aligner
    import vfa_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int MAX_VEC_LOG2 = 10,
    parameter int CORE_LAT     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        cfg_vec_log2,
    input  logic [3:0]        cfg_pkt_log2,
    input  logic [3:0]        cfg_grp_log2,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    input  logic [11:0]       s_seq,
    input  logic              s_eob,
    input  logic              s_ovf,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_last,
    output logic              m_vlast,
    output logic              cfg_err,
    output logic [15:0]       drop_cnt,
    output logic [15:0]       realign_cnt
);
    localparam int VEC_AW = MAX_VEC_LOG2;

    logic              drain_busy, vec_done, wr_en;
    logic [VEC_AW-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] rd_data;

    vfa_tracker #(.VEC_AW(VEC_AW)) trk_i (
        .clk(clk), .rst(rst),
        .cfg_vec_log2(cfg_vec_log2), .cfg_pkt_log2(cfg_pkt_log2), .cfg_grp_log2(cfg_grp_log2),
        .s_valid(s_valid), .s_last(s_last), .s_seq(s_seq), .s_eob(s_eob), .s_ovf(s_ovf),
        .drain_busy(drain_busy), .s_ready(s_ready),
        .wr_en(wr_en), .wr_addr(wr_addr), .vec_done(vec_done),
        .cfg_err(cfg_err), .drop_cnt(drop_cnt), .realign_cnt(realign_cnt)
    );

    vfa_store #(.DATA_W(DATA_W), .VEC_AW(VEC_AW)) store_i (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(s_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    vfa_drain #(.DATA_W(DATA_W), .VEC_AW(VEC_AW), .LAT(CORE_LAT)) drain_i (
        .clk(clk), .rst(rst),
        .cfg_vec_log2(cfg_vec_log2), .cfg_pkt_log2(cfg_pkt_log2),
        .vec_done(vec_done), .rd_addr(rd_addr), .rd_data(rd_data),
        .m_ready(m_ready), .m_valid(m_valid), .m_data(m_data),
        .m_last(m_last), .m_vlast(m_vlast), .busy(drain_busy)
    );
endmodule

// File: rtl/vfa_checker.sv
`timescale 1ns/1ps
module vfa_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              s_ready,
    input logic              m_valid,
    input logic              m_ready,
    input logic [DATA_W-1:0] m_data,
    input logic              m_last,
    input logic              m_vlast,
    input logic              cfg_err,
    input logic [15:0]       drop_cnt,
    input logic [15:0]       realign_cnt,
    input logic              drain_busy
);
    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last) && $stable(m_vlast)));

    assert_drain_stalls_input_R11: assert property (@(posedge clk) disable iff (rst)
        (drain_busy && !cfg_err) |-> !s_ready);

    assert_vlast_with_last_R3: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_vlast) |-> m_last);

    assert_drop_step_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((drop_cnt == $past(drop_cnt)) || (drop_cnt == $past(drop_cnt) + 16'd1)));

    assert_realign_step_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((realign_cnt == $past(realign_cnt)) || (realign_cnt == $past(realign_cnt) + 16'd1)));

    assert_drop_sat_R10: assert property (@(posedge clk) disable iff (rst)
        (drop_cnt == 16'hFFFF) |=> (drop_cnt == 16'hFFFF));

    assert_realign_sat_R10: assert property (@(posedge clk) disable iff (rst)
        (realign_cnt == 16'hFFFF) |=> (realign_cnt == 16'hFFFF));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);
endmodule

bind vec_frame_aligner vfa_checker #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst(rst), .s_ready(s_ready), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_last(m_last), .m_vlast(m_vlast), .cfg_err(cfg_err),
    .drop_cnt(drop_cnt), .realign_cnt(realign_cnt), .drain_busy(drain_busy)
);

// File: tb/vec_frame_aligner_tb_top.sv
`timescale 1ns/1ps
module vec_frame_aligner_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_vec_log2 = 4'd3, cfg_pkt_log2 = 4'd2, cfg_grp_log2 = 4'd1;
    logic        s_valid = 1'b0, s_last = 1'b0, s_eob = 1'b0, s_ovf = 1'b0;
    logic [31:0] s_data = '0;
    logic [11:0] s_seq = '0;
    logic        s_ready, m_valid, m_last, m_vlast, cfg_err;
    logic        m_ready = 1'b1;
    logic [31:0] m_data;
    logic [15:0] drop_cnt, realign_cnt;

    int checks = 0, errors = 0, cyc = 0;
    bit bp_en = 1'b0, finished = 1'b0;
    int exp_drop = 0, exp_realign = 0;
    logic [33:0] capq[$];
    logic [33:0] expq[$];

    always #10 clk = ~clk;

    vec_frame_aligner dut_i (
        .clk(clk), .rst(rst),
        .cfg_vec_log2(cfg_vec_log2), .cfg_pkt_log2(cfg_pkt_log2), .cfg_grp_log2(cfg_grp_log2),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
        .s_seq(s_seq), .s_eob(s_eob), .s_ovf(s_ovf),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
        .m_vlast(m_vlast), .cfg_err(cfg_err), .drop_cnt(drop_cnt), .realign_cnt(realign_cnt)
    );

    always @(negedge clk) begin
        cyc++;
        m_ready = bp_en ? (cyc % 3 != 2) : 1'b1;
        if (m_valid && m_ready) capq.push_back({m_last, m_vlast, m_data});
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_pkt(input int seq, input int nbeats, input bit eob, input int ovf_beat);
        for (int b = 0; b < nbeats; b++) begin
            @(negedge clk);
            s_valid = 1'b1;
            s_seq   = 12'(seq);
            s_data  = {16'(seq), 16'(b)};
            s_last  = (b == nbeats - 1);
            s_eob   = eob && (b == nbeats - 1);
            s_ovf   = (b == ovf_beat);
            while (!s_ready) @(negedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0;
        s_last  = 1'b0;
        s_eob   = 1'b0;
        s_ovf   = 1'b0;
    endtask

    task automatic exp_pkt(input int seq);
        for (int b = 0; b < 4; b++) begin
            int idx;
            idx = expq.size();
            expq.push_back({b == 3, idx % 8 == 7, 16'(seq), 16'(b)});
        end
    endtask

    task automatic compare_out(input string req);
        int bad;
        bad = -1;
        repeat (40) @(negedge clk);
        chk(capq.size() == expq.size(), {req, " sample count"}, capq.size(), expq.size());
        for (int i = 0; i < capq.size() && i < expq.size(); i++)
            if (bad < 0 && capq[i] != expq[i]) bad = i;
        if (bad >= 0) chk(1'b0, {req, " sample content"}, capq[bad], expq[bad]);
        else          chk(1'b1, {req, " sample content"}, 0, 0);
        capq.delete();
        expq.delete();
    endtask

    task automatic check_counts(input string req);
        chk(drop_cnt == 16'(exp_drop), {req, " drop_cnt"}, drop_cnt, exp_drop);
        chk(realign_cnt == 16'(exp_realign), {req, " realign_cnt"}, realign_cnt, exp_realign);
    endtask

    task automatic t_reset();
        do_reset();
        chk(m_valid == 1'b0, "R1 m_valid", m_valid, 0);
        chk(s_ready == 1'b1, "R1 s_ready", s_ready, 1);
        chk(cfg_err == 1'b0, "R1 cfg_err", cfg_err, 0);
        check_counts("R1");
    endtask

    task automatic t_normal();
        for (int p = 0; p < 4; p++) begin send_pkt(p, 4, 0, -1); exp_pkt(p); end
        compare_out("R2 R3 in-order vectors");
        check_counts("R2");
    endtask

    task automatic t_gap();
        send_pkt(4, 4, 0, -1);
        send_pkt(6, 4, 0, -1);
        send_pkt(7, 4, 0, -1);
        exp_pkt(6); exp_pkt(7);
        exp_drop++; exp_realign++;
        compare_out("R4 gap mid-vector");
        check_counts("R4");
    endtask

    task automatic t_hunt();
        send_pkt(9, 4, 0, -1);
        send_pkt(10, 4, 0, -1);
        send_pkt(11, 4, 0, -1);
        exp_pkt(10); exp_pkt(11);
        exp_realign++;
        compare_out("R5 hunt to position 0");
        check_counts("R5");
    endtask

    task automatic t_ovf();
        send_pkt(12, 4, 0, 1);
        send_pkt(13, 4, 0, -1);
        send_pkt(14, 4, 0, -1);
        send_pkt(15, 4, 0, -1);
        exp_pkt(14); exp_pkt(15);
        exp_drop++;
        compare_out("R6 overflow discards vector");
        check_counts("R6");
    endtask

    task automatic t_eob();
        send_pkt(16, 4, 1, -1);
        send_pkt(17, 4, 0, -1);
        send_pkt(18, 4, 0, -1);
        send_pkt(19, 4, 0, -1);
        send_pkt(20, 4, 1, -1);
        send_pkt(30, 4, 0, -1);
        send_pkt(31, 4, 0, -1);
        exp_pkt(17); exp_pkt(18); exp_pkt(19); exp_pkt(20); exp_pkt(30); exp_pkt(31);
        exp_drop++;
        compare_out("R7 end-of-burst restarts phase");
        check_counts("R7");
    endtask

    task automatic t_len();
        send_pkt(32, 3, 0, -1);
        send_pkt(33, 4, 0, -1);
        send_pkt(34, 4, 0, -1);
        send_pkt(35, 4, 0, -1);
        exp_pkt(34); exp_pkt(35);
        exp_drop++; exp_realign++;
        compare_out("R8 short packet");
        check_counts("R8");
    endtask

    task automatic t_backpressure();
        bp_en = 1'b1;
        send_pkt(36, 4, 0, -1);
        send_pkt(37, 4, 0, -1);
        chk(s_ready == 1'b0, "R11 s_ready low while draining", s_ready, 0);
        exp_pkt(36); exp_pkt(37);
        compare_out("R11 throttled output");
        bp_en = 1'b0;
        check_counts("R11");
    endtask

    task automatic t_cfg();
        cfg_vec_log2 = 4'd4;
        do_reset();
        @(negedge clk);
        chk(cfg_err == 1'b1, "R9 cfg_err set", cfg_err, 1);
        chk(s_ready == 1'b1, "R9 input consumed", s_ready, 1);
        send_pkt(0, 4, 0, -1);
        send_pkt(1, 4, 0, -1);
        compare_out("R9 no output under config error");
        cfg_vec_log2 = 4'd3;
        repeat (2) @(negedge clk);
        chk(cfg_err == 1'b1, "R9 cfg_err sticky", cfg_err, 1);
        do_reset();
        chk(cfg_err == 1'b0, "R9 cfg_err cleared by reset", cfg_err, 0);
    endtask

    initial begin
        t_reset();
        t_normal();
        t_gap();
        t_hunt();
        t_ovf();
        t_eob();
        t_len();
        t_backpressure();
        t_cfg();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule